// File: doc/BRIEF.md
# Dual Word FIFO with Flush

This block sits between a register bus and a serial bus engine and buffers 32-bit words in both directions. Each word carries four bytes of serial data. Software pushes words into the transmit queue by writing a data address and pops words from the receive queue by reading another. The engine drains the transmit queue and fills the receive queue through plain valid/ready handshakes.

A control word holds a per-direction flush request and a 3-bit trigger threshold for each direction. A flush clears its queue and then holds for two cycles. Its control bit reads back as 1 while the flush is in progress and then clears itself, so software can poll it. A status word packs the number of free transmit slots and the number of filled receive slots. Each direction drives a data-request line, derived from its threshold, that tells software when to service the queue.

Top module: `wfifo_pair`

## Requirements
- R1: Words written to address 2 leave on `tx_data_o` in write order, one per cycle in which `tx_valid_o` and `tx_ready_i` are both high; the queue holds 8 words.
- R2: A write to address 0 loads the transmit threshold from bits 7:5 and the receive threshold from bits 4:2. Reading address 0 returns the thresholds in those same fields, with the transmit flush-busy flag in bit 1 and the receive flush-busy flag in bit 0.
- R3: A write to address 2 while the transmit queue holds 8 words is dropped, and `tx_ovf_o` is high in that same cycle.
- R4: A read of address 3 while the receive queue is empty returns zero and raises `rx_unf_o` in that cycle; it changes no state.
- R5: Writing 1 to bit 1 (transmit) or bit 0 (receive) of address 0 starts a flush of that queue; both may be set in one write. The matching busy bit reads 1 for the two cycles after the write and 0 after that.
- R6: A flush empties its queue at the write edge. Until the flush completes, engine-side transfers on that queue are held off (`tx_valid_o` or `rx_ready_o` is low), bus pushes to that queue are dropped, and its request line is low.
- R7: Reading address 1 returns the free transmit slot count in bits 7:4 and the filled receive slot count in bits 3:0; all other bits are zero.
- R8: `tx_req_o` is high when no transmit flush is busy and the free transmit slot count is at least the transmit threshold plus 1.
- R9: `rx_req_o` is high when no receive flush is busy and the filled receive count is at least the receive threshold plus 1. A threshold of 0 therefore raises the request as soon as one word is present.
- R10: Words accepted from the engine, when `rx_valid_i` and `rx_ready_o` are both high, are returned by reads of address 3 in arrival order; `rx_ready_o` is low when the receive queue holds 8 words.
- R11: After reset both queues are empty, both thresholds are 0, no flush is busy, and the status word reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_wr_i | input | 1 | Bus write strobe |
| csr_rd_i | input | 1 | Bus read strobe (a read of address 3 pops) |
| csr_addr_i | input | 2 | Word address: 0 control, 1 status, 2 transmit data, 3 receive data |
| csr_wdata_i | input | 32 | Bus write data |
| csr_rdata_o | output | 32 | Bus read data, combinational from address |
| tx_valid_o | output | 1 | Transmit word available to engine |
| tx_data_o | output | 32 | Transmit head word |
| tx_ready_i | input | 1 | Engine takes the transmit word |
| rx_valid_i | input | 1 | Engine offers a receive word |
| rx_data_i | input | 32 | Receive word from engine |
| rx_ready_o | output | 1 | Block accepts the receive word |
| tx_req_o | output | 1 | Transmit data request |
| rx_req_o | output | 1 | Receive data request |
| tx_ovf_o | output | 1 | Push to a full transmit queue this cycle |
| rx_unf_o | output | 1 | Pop from an empty receive queue this cycle |

## Verification
A pointer or count that drifts from the true occupancy shows in the status word and in both request lines in the very next cycle. That makes per-cycle comparison against a queue model effective. A bad flush timer shows as a busy bit held one cycle too long or too short when polled at address 0. It can also show as an engine handshake that stays open during the hold window. Corrupted storage or ordering appears on `tx_data_o` or on receive reads as soon as the affected word reaches the head.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_TXD  = 2'd2,
    A_RXD  = 2'd3
  } csr_addr_e;

  localparam int RXF_BIT = 0;
  localparam int TXF_BIT = 1;
  localparam int RXT_LSB = 2;
  localparam int TXT_LSB = 5;
  localparam int THR_W   = 3;
  localparam int STAT_W  = 4;
endpackage

// File: rtl/wfifo_core.sv
module wfifo_core #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/wfifo_flush.sv
module wfifo_flush #(
  parameter int STAGES = 2,
  localparam int SW    = $clog2(STAGES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [SW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (start_i)        left_q <= SW'(STAGES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/wfifo_pair.sv
module wfifo_pair
  import wfifo_pkg::*;
#(
  parameter int DW      = 32,
  parameter int DEPTH   = 8,
  parameter int FL_CYC  = 2,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int CMPW   = ((CW > THR_W) ? CW : THR_W) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          csr_wr_i,
  input  logic          csr_rd_i,
  input  logic [1:0]    csr_addr_i,
  input  logic [DW-1:0] csr_wdata_i,
  output logic [DW-1:0] csr_rdata_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ready_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          rx_ready_o,
  output logic          tx_req_o,
  output logic          rx_req_o,
  output logic          tx_ovf_o,
  output logic          rx_unf_o
);
  logic [THR_W-1:0] tx_thr_q, rx_thr_q;
  logic             ctrl_wr, tx_start, rx_start, tx_busy, rx_busy, tx_clr, rx_clr;
  logic [CW-1:0]    tx_cnt, rx_cnt, tx_free;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0]    rx_head;

  assign ctrl_wr  = csr_wr_i && (csr_addr_i == A_CTRL);
  assign tx_start = ctrl_wr && csr_wdata_i[TXF_BIT];
  assign rx_start = ctrl_wr && csr_wdata_i[RXF_BIT];
  assign tx_clr   = tx_start || tx_busy;
  assign rx_clr   = rx_start || rx_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (ctrl_wr) begin
      tx_thr_q <= csr_wdata_i[TXT_LSB +: THR_W];
      rx_thr_q <= csr_wdata_i[RXT_LSB +: THR_W];
    end
  end

  wfifo_flush #(.STAGES(FL_CYC)) u_tx_fl (
    .clk_i, .rst_ni, .start_i(tx_start), .busy_o(tx_busy)
  );
  wfifo_flush #(.STAGES(FL_CYC)) u_rx_fl (
    .clk_i, .rst_ni, .start_i(rx_start), .busy_o(rx_busy)
  );

  // clear has priority inside the core, so the handshakes are gated by it
  assign tx_valid_o = !tx_empty && !tx_clr;
  assign rx_ready_o = !rx_full && !rx_clr;

  wfifo_core #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .clr_i   (tx_clr),
    .push_i  (csr_wr_i && (csr_addr_i == A_TXD)),
    .wdata_i (csr_wdata_i),
    .pop_i   (tx_valid_o && tx_ready_i),
    .rdata_o (tx_data_o),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  wfifo_core #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .clr_i   (rx_clr),
    .push_i  (rx_valid_i && rx_ready_o),
    .wdata_i (rx_data_i),
    .pop_i   (csr_rd_i && (csr_addr_i == A_RXD)),
    .rdata_o (rx_head),
    .count_o (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign tx_free  = CW'(DEPTH) - tx_cnt;
  assign tx_req_o = !tx_busy && (CMPW'(tx_free) > CMPW'(tx_thr_q));
  assign rx_req_o = !rx_busy && (CMPW'(rx_cnt) > CMPW'(rx_thr_q));
  assign tx_ovf_o = csr_wr_i && (csr_addr_i == A_TXD) && tx_full;
  assign rx_unf_o = csr_rd_i && (csr_addr_i == A_RXD) && rx_empty;

  always_comb begin
    unique case (csr_addr_i)
      A_CTRL:  csr_rdata_o = DW'({tx_thr_q, rx_thr_q, tx_busy, rx_busy});
      A_STAT:  csr_rdata_o = DW'({STAT_W'(tx_free), STAT_W'(rx_cnt)});
      A_RXD:   csr_rdata_o = rx_empty ? '0 : rx_head;
      default: csr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wfifo_pair_chk.sv
module wfifo_pair_chk
  import wfifo_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          csr_wr_i,
  input logic [1:0]    csr_addr_i,
  input logic [DW-1:0] csr_wdata_i,
  input logic [DW-1:0] csr_rdata_o,
  input logic          tx_valid_o,
  input logic          rx_ready_o,
  input logic          tx_req_o,
  input logic          rx_req_o,
  input logic          tx_ovf_o,
  input logic          rx_unf_o,
  input logic          tx_busy,
  input logic          rx_busy,
  input logic [2:0]    rx_thr_q,
  input logic [3:0]    rx_cnt
);
  logic ctl_w;
  assign ctl_w = csr_wr_i && (csr_addr_i == A_CTRL);

  p_unf_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_unf_o |-> (csr_rdata_o == '0));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_o |-> (!tx_req_o && csr_wr_i));

  p_tx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_w && csr_wdata_i[TXF_BIT]) |=> (!tx_valid_o && !tx_req_o));

  p_rx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_w && csr_wdata_i[RXF_BIT]) |=> (!rx_ready_o && !rx_req_o));

  p_busy_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_w && csr_wdata_i[TXF_BIT]) |=> tx_busy);

  p_rx_req_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_thr_q == '0 && rx_cnt != '0 && !rx_busy) |-> rx_req_o);
endmodule

bind wfifo_pair wfifo_pair_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .csr_wr_i, .csr_addr_i, .csr_wdata_i, .csr_rdata_o,
  .tx_valid_o, .rx_ready_o, .tx_req_o, .rx_req_o, .tx_ovf_o, .rx_unf_o,
  .tx_busy, .rx_busy, .rx_thr_q, .rx_cnt
);

// File: tb/wfifo_pair_tb.sv
module wfifo_pair_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        csr_wr_i = 1'b0, csr_rd_i = 1'b0;
  logic [1:0]  csr_addr_i = '0;
  logic [31:0] csr_wdata_i = '0, rx_data_i = '0;
  logic        tx_ready_i = 1'b0, rx_valid_i = 1'b0;
  logic [31:0] csr_rdata_o, tx_data_o;
  logic        tx_valid_o, rx_ready_o, tx_req_o, rx_req_o, tx_ovf_o, rx_unf_o;

  always #4 clk = ~clk;

  wfifo_pair u_dut (
    .clk_i(clk), .rst_ni, .csr_wr_i, .csr_rd_i, .csr_addr_i, .csr_wdata_i,
    .csr_rdata_o, .tx_valid_o, .tx_data_o, .tx_ready_i, .rx_valid_i,
    .rx_data_i, .rx_ready_o, .tx_req_o, .rx_req_o, .tx_ovf_o, .rx_unf_o
  );

  int total = 0, bad = 0;
  logic [31:0] txq[$], rxq[$];
  int tthr = 0, rthr = 0, tfl = 0, rfl = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                     input logic [31:0] wd, input logic tr, input logic rv,
                     input logic [31:0] rdat);
    int tsz, rsz;
    bit tbusy, rbusy, st_t, st_r, tclr, rclr, e_tv, e_rr, ctrlw;
    logic [31:0] e_rd;
    csr_wr_i = wr; csr_rd_i = rd; csr_addr_i = a; csr_wdata_i = wd;
    tx_ready_i = tr; rx_valid_i = rv; rx_data_i = rdat;
    #1;
    tsz = txq.size(); rsz = rxq.size();
    tbusy = tfl > 0; rbusy = rfl > 0;
    ctrlw = wr && a == 2'd0;
    st_t = ctrlw && wd[1]; st_r = ctrlw && wd[0];
    tclr = st_t || tbusy; rclr = st_r || rbusy;
    e_tv = !tclr && tsz > 0;
    e_rr = !rclr && rsz < 8;
    case (a)
      2'd0: e_rd = {24'd0, 3'(tthr), 3'(rthr), tbusy, rbusy};
      2'd1: e_rd = {24'd0, 4'(8 - tsz), 4'(rsz)};
      2'd3: e_rd = (rsz > 0) ? rxq[0] : 32'd0;
      default: e_rd = 32'd0;
    endcase
    chk((a == 2'd0) ? "R2/R5 ctrl" : (a == 2'd1) ? "R7 status" : "R10/R4 rdata",
        csr_rdata_o, e_rd);
    chk("R6 tx_valid", 32'(tx_valid_o), 32'(e_tv));
    if (e_tv) chk("R1 tx_data", tx_data_o, txq[0]);
    chk("R6/R10 rx_ready", 32'(rx_ready_o), 32'(e_rr));
    chk("R8 tx_req", 32'(tx_req_o), 32'(!tbusy && (8 - tsz) > tthr));
    chk("R9 rx_req", 32'(rx_req_o), 32'(!rbusy && rsz > rthr));
    chk("R3 tx_ovf", 32'(tx_ovf_o), 32'(wr && a == 2'd2 && tsz == 8));
    chk("R4 rx_unf", 32'(rx_unf_o), 32'(rd && a == 2'd3 && rsz == 0));
    @(posedge clk);
    if (tclr) txq.delete();
    else begin
      if (e_tv && tr) void'(txq.pop_front());
      if (wr && a == 2'd2 && tsz < 8) txq.push_back(wd);
    end
    if (rclr) rxq.delete();
    else begin
      if (rd && a == 2'd3 && rsz > 0) void'(rxq.pop_front());
      if (rv && e_rr) rxq.push_back(rdat);
    end
    if (st_t) tfl = 2; else if (tfl > 0) tfl--;
    if (st_r) rfl = 2; else if (rfl > 0) rfl--;
    if (ctrlw) begin tthr = int'(wd[7:5]); rthr = int'(wd[4:2]); end
    @(negedge clk);
  endtask

  task automatic idle(input logic [1:0] a);
    cyc(1'b0, 1'b0, a, 32'd0, 1'b0, 1'b0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R11 reset state
    chk("R11 status", csr_rdata_o, 32'h0000_0000);  // addr 0: ctrl all zero
    csr_addr_i = 2'd1; #1;
    chk("R11 status", csr_rdata_o, 32'h0000_0080);
    chk("R11 tx_valid", 32'(tx_valid_o), 32'd0);
    @(negedge clk);
    idle(2'd1);
    // R2 thresholds: tx 3, rx 0
    cyc(1'b1, 1'b0, 2'd0, 32'h60, 1'b0, 1'b0, 0);
    idle(2'd0);
    // R1/R3: fill beyond depth
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, 2'd2, 32'hA000_0000 + i, 1'b0, 1'b0, 0);
    idle(2'd1);
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 2'd1, 0, 1'b1, 1'b0, 0);
    // R10/R9: engine fills rx past depth
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 2'd1, 0, 1'b0, 1'b1, 32'hB000_0000 + i);
    for (int i = 0; i < 9; i++) cyc(1'b0, 1'b1, 2'd3, 0, 1'b0, 1'b0, 0);  // last one underflows (R4)
    // R5/R6: flush both at once with content present
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 2'd2, 32'hC000_0000 + i, 1'b0, 1'b1, 32'hD000_0000 + i);
    cyc(1'b1, 1'b0, 2'd0, 32'h0000_0047, 1'b1, 1'b1, 32'hEEEE_0000);
    cyc(1'b1, 1'b0, 2'd2, 32'hDEAD_0001, 1'b1, 1'b1, 32'hEEEE_0001);
    cyc(1'b0, 1'b1, 2'd3, 0, 1'b1, 1'b1, 32'hEEEE_0002);
    idle(2'd0);
    idle(2'd1);
    // tx-only flush, rx keeps data
    cyc(1'b0, 1'b0, 2'd1, 0, 1'b0, 1'b1, 32'h1234_5678);
    cyc(1'b1, 1'b0, 2'd0, 32'h0000_0002, 1'b0, 1'b0, 0);
    idle(2'd0); idle(2'd0); idle(2'd3);
    // mixed traffic
    for (int i = 0; i < 2500; i++) begin
      int op;
      logic [31:0] w;
      op = int'($urandom_range(0, 19));
      w = $urandom;
      case (op)
        0:       cyc(1'b1, 1'b0, 2'd0, {24'd0, w[7:2], (w[8] ? w[1:0] : 2'b00)},
                     w[9], w[10], $urandom);
        1, 2:    cyc(1'b0, 1'b1, 2'd0, 0, w[9], w[10], $urandom);
        3, 4:    cyc(1'b0, 1'b1, 2'd1, 0, w[9], w[10], $urandom);
        5, 6, 7, 8, 9: cyc(1'b1, 1'b0, 2'd2, w, w[9], w[10], $urandom);
        10, 11, 12, 13: cyc(1'b0, 1'b1, 2'd3, 0, w[9], w[10], $urandom);
        default: cyc(1'b0, 1'b0, 2'(w[1:0]), 0, w[9], w[10], $urandom);
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule